// File: doc/BRIEF.md
# Unaligned Word Merge Unit

This block carries out the four partial-word memory operations of a 32-bit big-endian RISC core. The four operations are load-left, load-right, store-left and store-right. Software uses them in pairs to move a word that is not aligned to a word boundary. For every request the unit clears the low address bits and reads the aligned word. The two discarded bits are the byte offset, and the offset decides which bytes are merged.

For a load, the fetched word is shifted, and the bytes that the offset does not cover keep their value from the destination register. The merged value is then handed back for write-back. For a store, the register is shifted into the lanes the offset selects, the remaining lanes keep the bytes just read, and the whole word is written back to the same aligned address. This is a read-modify-write.

A load result that is written back can be used again at once. When the next request names that register, the unit takes the new value itself and does not use the stale value from the register file. This lets a load-left and load-right pair chain with no gap between them. Register 0 is never written.

Top module: `uwm_merge_unit`

## Requirements
- R1: Every memory read and write is addressed with the request address whose two least significant bits are forced to zero.
- R2: Operation code 0 (load-left), at byte offset k, returns the memory word shifted left by 8*(3-k) bits. The register's low 3-k bytes are kept: offset 0 keeps 0x00FFFFFF, offset 3 keeps nothing.
- R3: Operation code 1 (load-right), at byte offset k, returns the memory word shifted right by 8*k bits. The register's top k bytes are kept: offset 1 keeps 0xFF000000.
- R4: Operation code 2 (store-left), at byte offset k, writes the register shifted right by 8*(3-k) bits. The memory's top 3-k bytes are kept: offset 0 keeps 0xFFFFFF00, offset 3 keeps nothing.
- R5: Operation code 3 (store-right), at byte offset k, writes the register shifted left by 8*k bits. The memory's low k bytes are kept: offset 1 keeps 0x000000FF.
- R6: A store first holds a read request until read data returns. In the very next cycle it raises a write request, and the write request, address and data stay stable until the acknowledge. `done` pulses in the cycle after the acknowledge.
- R7: A load pulses `done` in the cycle after read data returns. In that same cycle `ld_wen` is high, and `ld_rt` and `ld_data` carry the result. A store never raises `ld_wen`.
- R8: A load whose destination index is 0 never raises `ld_wen`.
- R9: A request accepted in the cycle where `ld_wen` is high and `ld_rt` equals the request's register index uses `ld_data` in place of `req_reg_val`.
- R10: `req_valid` is ignored while `busy` is high: no extra memory access and no extra `done` follows.
- R11: During and after reset, `busy`, `done`, `ld_wen`, `mem_rd_req` and `mem_wr_req` are low.
- R12: A read request and a write request are never raised in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_op | input | 2 | 0 load-left, 1 load-right, 2 store-left, 3 store-right |
| req_addr | input | 32 | Byte address of the access |
| req_rt | input | 5 | Register index (load destination or store source) |
| req_reg_val | input | 32 | Current value of that register |
| busy | output | 1 | An operation is in progress |
| mem_rd_req | output | 1 | Read request, held until read data returns |
| mem_wr_req | output | 1 | Write request, held until acknowledged |
| mem_addr | output | 32 | Aligned word address |
| mem_wdata | output | 32 | Merged word to write |
| mem_rdata | input | 32 | Read data |
| mem_rvalid | input | 1 | Read data valid |
| mem_wack | input | 1 | Write acknowledge |
| done | output | 1 | One-cycle completion pulse |
| ld_wen | output | 1 | Load result write enable |
| ld_rt | output | 5 | Load destination index |
| ld_data | output | 32 | Merged load result |

## Verification
The checks assume the memory side raises `mem_rvalid` only while a read request is pending, and `mem_wack` only while a write request is pending. The sequencing properties rely on this, for example a write starting only after data has returned. The bench's memory responder keeps to that rule. It waits to see each request before it answers it with a single-cycle response. While a request is pending, the bench holds `req_valid` either low or on purpose high, which exercises the ignore-while-busy rule. It never raises a response strobe out of turn.

// File: rtl/uwm_pkg.sv
// Shared types for the unaligned word merge unit.
// Assumes the operation encoding is fixed: bit 1 selects store, bit 0 selects the right-hand variant.
package uwm_pkg;

    typedef enum logic [1:0] {
        OP_LD_LEFT  = 2'd0,
        OP_LD_RIGHT = 2'd1,
        OP_ST_LEFT  = 2'd2,
        OP_ST_RIGHT = 2'd3
    } merge_op_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_READ  = 2'd1,
        SQ_WRITE = 2'd2
    } seq_state_e;

    // True for the two store operations
    function automatic logic op_is_store(input logic [1:0] op);
        return op[1];
    endfunction

    // True for the right-hand variants
    function automatic logic op_is_right(input logic [1:0] op);
        return op[0];
    endfunction

endpackage

// File: rtl/uwm_load_merge.sv
// Load byte merge: combines the fetched aligned word with the destination register.
// Left variant: memory shifted toward the top; the register's low NB-1-ofs lanes are kept.
// Right variant: memory shifted toward the bottom; the register's top ofs lanes are kept.
// Assumes DATA_W is a multiple of 8 and holds a power-of-two number of bytes.
module uwm_load_merge #(
    parameter int DATA_W = 32,
    localparam int NB    = DATA_W / 8,
    localparam int OFS_W = $clog2(NB)
) (
    input  logic              from_right,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DATA_W-1:0] mem_word,
    input  logic [DATA_W-1:0] reg_val,
    output logic [DATA_W-1:0] result
);

    logic [DATA_W-1:0] keep;
    logic [DATA_W-1:0] shifted;
    int                sh_bits;

    // Per-lane register-keep mask, one lane per byte
    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign keep[b*8 +: 8] = from_right ? {8{(b >= NB - int'(ofs))}}
                                           : {8{(b < NB - 1 - int'(ofs))}};
    end

    // Shift the memory word into the lanes being replaced
    always_comb begin
        if (from_right) begin
            sh_bits = int'(ofs) * 8;
            shifted = mem_word >> sh_bits;
        end else begin
            sh_bits = (NB - 1 - int'(ofs)) * 8;
            shifted = mem_word << sh_bits;
        end
    end

    // Combine kept register lanes with shifted memory lanes
    assign result = (reg_val & keep) | (shifted & ~keep);

endmodule

// File: rtl/uwm_store_merge.sv
// Store byte merge: combines the register with the aligned word just read.
// Left variant: register shifted toward the bottom; memory's top NB-1-ofs lanes are kept.
// Right variant: register shifted toward the top; memory's low ofs lanes are kept.
// Assumes DATA_W is a multiple of 8 and holds a power-of-two number of bytes.
module uwm_store_merge #(
    parameter int DATA_W = 32,
    localparam int NB    = DATA_W / 8,
    localparam int OFS_W = $clog2(NB)
) (
    input  logic              from_right,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DATA_W-1:0] mem_word,
    input  logic [DATA_W-1:0] reg_val,
    output logic [DATA_W-1:0] result
);

    logic [DATA_W-1:0] keep;
    logic [DATA_W-1:0] shifted;
    int                sh_bits;

    // Per-lane memory-keep mask, one lane per byte
    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign keep[b*8 +: 8] = from_right ? {8{(b < int'(ofs))}}
                                           : {8{(b >= int'(ofs) + 1)}};
    end

    // Shift the register into the lanes being overwritten
    always_comb begin
        if (from_right) begin
            sh_bits = int'(ofs) * 8;
            shifted = reg_val << sh_bits;
        end else begin
            sh_bits = (NB - 1 - int'(ofs)) * 8;
            shifted = reg_val >> sh_bits;
        end
    end

    // Combine kept memory lanes with shifted register lanes
    assign result = (mem_word & keep) | (shifted & ~keep);

endmodule

// File: rtl/uwm_seq.sv
// Access sequencer: idle, read held until data returns, then (stores only) write held until acknowledged.
// Raises a one-cycle done after the load data or the write acknowledge.
// Assumes the memory answers only the request currently raised.
module uwm_seq
    import uwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_store,
    input  logic mem_rvalid,
    input  logic mem_wack,
    output logic accept,
    output logic capture,
    output logic store_q,
    output logic rd_req,
    output logic wr_req,
    output logic busy,
    output logic done
);

    seq_state_e state_q;
    logic       done_q;

    assign accept  = (state_q == SQ_IDLE) && req_valid;
    assign capture = (state_q == SQ_READ) && mem_rvalid;
    assign rd_req  = (state_q == SQ_READ);
    assign wr_req  = (state_q == SQ_WRITE);
    assign busy    = (state_q != SQ_IDLE);
    assign done    = done_q;

    // State transitions and store flag capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            store_q <= 1'b0;
        end else begin
            unique case (state_q)
                SQ_IDLE: if (accept) begin
                    state_q <= SQ_READ;
                    store_q <= req_store;
                end
                SQ_READ: if (mem_rvalid) begin
                    state_q <= store_q ? SQ_WRITE : SQ_IDLE;
                end
                SQ_WRITE: if (mem_wack) begin
                    state_q <= SQ_IDLE;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // Completion pulse one cycle after the final handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= (capture && !store_q) || ((state_q == SQ_WRITE) && mem_wack);
        end
    end

endmodule

// File: rtl/uwm_merge_unit.sv
// Unaligned word merge unit top level.
// Captures a request, aligns its address, reads the aligned word, and either returns a merged load
// value or writes back a merged word. Forwards its own just-written load result to the next request.
// Assumes one operation at a time; requests while busy are dropped.
module uwm_merge_unit
    import uwm_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 32,
    parameter int REG_IDX_W = 5,
    localparam int NB       = DATA_W / 8,
    localparam int OFS_W    = $clog2(NB)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [1:0]           req_op,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [REG_IDX_W-1:0] req_rt,
    input  logic [DATA_W-1:0]    req_reg_val,
    output logic                 busy,
    output logic                 mem_rd_req,
    output logic                 mem_wr_req,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic [DATA_W-1:0]    mem_rdata,
    input  logic                 mem_rvalid,
    input  logic                 mem_wack,
    output logic                 done,
    output logic                 ld_wen,
    output logic [REG_IDX_W-1:0] ld_rt,
    output logic [DATA_W-1:0]    ld_data
);

    logic                 accept;
    logic                 capture;
    logic                 store_q;
    logic [1:0]           op_q;
    logic [OFS_W-1:0]     ofs_q;
    logic [ADDR_W-1:0]    addr_q;
    logic [REG_IDX_W-1:0] rt_q;
    logic [DATA_W-1:0]    src_q;
    logic [DATA_W-1:0]    ld_data_q;
    logic                 ld_wen_q;
    logic [DATA_W-1:0]    wdata_q;
    logic [DATA_W-1:0]    load_result;
    logic [DATA_W-1:0]    store_result;
    logic                 fwd_hit;

    uwm_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_store  (op_is_store(req_op)),
        .mem_rvalid (mem_rvalid),
        .mem_wack   (mem_wack),
        .accept     (accept),
        .capture    (capture),
        .store_q    (store_q),
        .rd_req     (mem_rd_req),
        .wr_req     (mem_wr_req),
        .busy       (busy),
        .done       (done)
    );

    uwm_load_merge #(.DATA_W(DATA_W)) u_ld (
        .from_right (op_is_right(op_q)),
        .ofs        (ofs_q),
        .mem_word   (mem_rdata),
        .reg_val    (src_q),
        .result     (load_result)
    );

    uwm_store_merge #(.DATA_W(DATA_W)) u_st (
        .from_right (op_is_right(op_q)),
        .ofs        (ofs_q),
        .mem_word   (mem_rdata),
        .reg_val    (src_q),
        .result     (store_result)
    );

    // Same-register forward from the load result being written this cycle
    assign fwd_hit = ld_wen_q && (ld_rt == req_rt);

    // Request capture with address alignment and register forwarding
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_LD_LEFT;
            ofs_q  <= '0;
            addr_q <= '0;
            rt_q   <= '0;
            src_q  <= '0;
        end else if (accept) begin
            op_q   <= req_op;
            ofs_q  <= req_addr[OFS_W-1:0];
            addr_q <= {req_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
            rt_q   <= req_rt;
            src_q  <= fwd_hit ? ld_data_q : req_reg_val;
        end
    end

    // Load result register and single-cycle write enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_data_q <= '0;
            ld_wen_q  <= 1'b0;
        end else begin
            if (capture && !store_q) begin
                ld_data_q <= load_result;
            end
            ld_wen_q <= capture && !store_q && (rt_q != '0);
        end
    end

    // Store data register, held stable for the write phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdata_q <= '0;
        end else if (capture && store_q) begin
            wdata_q <= store_result;
        end
    end

    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;
    assign ld_wen    = ld_wen_q;
    assign ld_rt     = rt_q;
    assign ld_data   = ld_data_q;

endmodule

// File: rtl/uwm_merge_unit_chk.sv
// Port-level property checker for the unaligned word merge unit, bound to every instance.
// Assumes the memory raises rvalid only while a read is pending and wack only while a write is pending.
module uwm_merge_unit_chk #(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 32,
    parameter int REG_IDX_W = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 busy,
    input logic                 mem_rd_req,
    input logic                 mem_wr_req,
    input logic [ADDR_W-1:0]    mem_addr,
    input logic [DATA_W-1:0]    mem_wdata,
    input logic                 mem_rvalid,
    input logic                 mem_wack,
    input logic                 done,
    input logic                 ld_wen,
    input logic [REG_IDX_W-1:0] ld_rt
);

    a_r12_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && mem_wr_req));

    a_r1_aligned_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req || mem_wr_req) |-> (mem_addr[1:0] == 2'b00));

    a_r6_write_follows_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_req) |-> $past(mem_rvalid && mem_rd_req));

    a_r6_write_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_wack) |=> (mem_wr_req && $stable(mem_wdata) && $stable(mem_addr)));

    a_r6_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && mem_wack) |=> done);

    a_r8_no_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
        ld_wen |-> (ld_rt != '0));

    a_r7_wen_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        ld_wen |-> done);

    a_r10_idle_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mem_rd_req || mem_wr_req));

endmodule

bind uwm_merge_unit uwm_merge_unit_chk #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .REG_IDX_W (REG_IDX_W)
) u_chk (.*);

// File: tb/uwm_merge_unit_tb_top.sv
`timescale 1ns/1ps
module uwm_merge_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [31:0] req_addr = '0;
    logic [4:0]  req_rt = '0;
    logic [31:0] req_reg_val = '0;
    logic        busy, mem_rd_req, mem_wr_req, done, ld_wen;
    logic [31:0] mem_addr, mem_wdata, ld_data;
    logic [31:0] mem_rdata = '0;
    logic        mem_rvalid = 1'b0;
    logic        mem_wack = 1'b0;
    logic [4:0]  ld_rt;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    uwm_merge_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_rt(req_rt), .req_reg_val(req_reg_val),
        .busy(busy), .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_rvalid(mem_rvalid), .mem_wack(mem_wack), .done(done),
        .ld_wen(ld_wen), .ld_rt(ld_rt), .ld_data(ld_data)
    );

    // Expected merges for mem 0x11223344, reg 0xAABBCCDD; index = op*4 + offset
    localparam logic [31:0] VEC_EXP [16] = '{
        32'h44BBCCDD, 32'h3344CCDD, 32'h223344DD, 32'h11223344,
        32'h11223344, 32'hAA112233, 32'hAABB1122, 32'hAABBCC11,
        32'h112233AA, 32'h1122AABB, 32'h11AABBCC, 32'hAABBCCDD,
        32'hAABBCCDD, 32'hBBCCDD44, 32'hCCDD3344, 32'hDD223344
    };
    localparam string OP_TAG [4] = '{"R2", "R3", "R4", "R5"};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Runs one operation from a negedge; returns at the negedge where done is expected
    task automatic run_op(input logic [1:0] op, input logic [31:0] addr, input logic [4:0] rt,
                          input logic [31:0] rv, input logic [31:0] mw, input bit junk,
                          output logic [31:0] got, output logic wen, output logic fin,
                          output logic [31:0] rd_addr, output logic wr_next);
        int n;
        req_valid = 1'b1; req_op = op; req_addr = addr; req_rt = rt; req_reg_val = rv;
        @(negedge clk);
        if (junk) begin req_op = 2'd3; req_addr = 32'h0000_0F03; end
        else req_valid = 1'b0;
        n = 0;
        while (!mem_rd_req && n < 50) begin @(negedge clk); n++; end
        rd_addr = mem_addr;
        mem_rdata = mw; mem_rvalid = 1'b1;
        @(negedge clk);
        mem_rvalid = 1'b0;
        wr_next = mem_wr_req;
        if (op[1]) begin
            n = 0;
            while (!mem_wr_req && n < 50) begin @(negedge clk); n++; end
            got = mem_wdata;
            mem_wack = 1'b1;
            @(negedge clk);
            mem_wack = 1'b0;
        end else begin
            got = ld_data;
        end
        wen = ld_wen;
        fin = done;
        req_valid = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL R6 watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] got, ra;
        logic wen, fin, wn;

        // R11: reset state
        repeat (3) @(negedge clk);
        check("R11 reset outputs", {27'd0, busy, done, ld_wen, mem_rd_req, mem_wr_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 after reset", {27'd0, busy, done, ld_wen, mem_rd_req, mem_wr_req}, 32'd0);

        // Vector walk over all ops and offsets
        for (int i = 0; i < 16; i++) begin
            logic [1:0] op;
            op = 2'(i / 4);
            run_op(op, 32'h1000_0100 + 32'(i % 4), 5'd3, 32'hAABBCCDD, 32'h11223344, 1'b0,
                   got, wen, fin, ra, wn);
            check(OP_TAG[i/4], got, VEC_EXP[i]);
            check("R1 aligned address", ra, 32'h1000_0100);
            check("R7/R6 done pulse", {31'd0, fin}, 32'd1);
            if (op[1]) begin
                check("R6 write next cycle", {31'd0, wn}, 32'd1);
                check("R7 store no ld_wen", {31'd0, wen}, 32'd0);
            end else begin
                check("R7 load ld_wen", {31'd0, wen}, 32'd1);
                check("R7 ld_rt", {27'd0, ld_rt}, 32'd3);
            end
            @(negedge clk);
            check("R7 done single pulse", {31'd0, done}, 32'd0);
        end

        // R9: load-left then load-right to r5 back to back, stale register value presented
        run_op(2'd0, 32'h2000_0001, 5'd5, 32'hAABBCCDD, 32'h11223344, 1'b0, got, wen, fin, ra, wn);
        check("R2 chain first", got, 32'h3344CCDD);
        run_op(2'd1, 32'h2000_0006, 5'd5, 32'hAABBCCDD, 32'h55667788, 1'b0, got, wen, fin, ra, wn);
        check("R9 chained load", got, 32'h33445566);
        check("R1 chain address", ra, 32'h2000_0004);

        // R9: load then store-right from the same register
        run_op(2'd0, 32'h2000_0003, 5'd7, 32'h0, 32'hCAFEF00D, 1'b0, got, wen, fin, ra, wn);
        run_op(2'd3, 32'h2000_0002, 5'd7, 32'h0, 32'h11223344, 1'b0, got, wen, fin, ra, wn);
        check("R9 forwarded store source", got, 32'hF00D3344);

        // R9: no forward when the index differs
        run_op(2'd0, 32'h2000_0003, 5'd8, 32'h0, 32'hCAFEF00D, 1'b0, got, wen, fin, ra, wn);
        run_op(2'd3, 32'h2000_0002, 5'd9, 32'h0, 32'h11223344, 1'b0, got, wen, fin, ra, wn);
        check("R9 no forward other index", got, 32'h00003344);

        // R8: destination 0 never written, and not forwarded
        run_op(2'd0, 32'h3000_0000, 5'd0, 32'h0, 32'h11223344, 1'b0, got, wen, fin, ra, wn);
        check("R8 rt0 no ld_wen", {31'd0, wen}, 32'd0);
        check("R8 rt0 still done", {31'd0, fin}, 32'd1);
        run_op(2'd1, 32'h3000_0002, 5'd0, 32'h0, 32'h11223344, 1'b0, got, wen, fin, ra, wn);
        check("R8 rt0 no forward", got, 32'h00001122);
        check("R8 rt0 no ld_wen second", {31'd0, wen}, 32'd0);

        // R10: request held high while busy is ignored
        run_op(2'd0, 32'h4000_0002, 5'd4, 32'hAABBCCDD, 32'h11223344, 1'b1, got, wen, fin, ra, wn);
        check("R10 busy op result", got, 32'h223344DD);
        begin
            int extra;
            extra = 0;
            for (int c = 0; c < 6; c++) begin
                @(negedge clk);
                if (mem_rd_req || mem_wr_req || done || busy) extra++;
            end
            check("R10 no extra access", 32'(extra), 32'd0);
        end

        // R6: slow write acknowledge keeps data stable
        begin
            int n;
            logic [31:0] w0;
            req_valid = 1'b1; req_op = 2'd2; req_addr = 32'h5000_0001; req_rt = 5'd2;
            req_reg_val = 32'h01020304;
            @(negedge clk); req_valid = 1'b0;
            n = 0;
            while (!mem_rd_req && n < 50) begin @(negedge clk); n++; end
            mem_rdata = 32'hA0B0C0D0; mem_rvalid = 1'b1;
            @(negedge clk); mem_rvalid = 1'b0;
            w0 = mem_wdata;
            check("R4 slow store data", w0, 32'hA0B00102);
            repeat (3) @(negedge clk);
            check("R6 write held", {31'd0, mem_wr_req}, 32'd1);
            check("R6 data stable", mem_wdata, w0);
            check("R6 no early done", {31'd0, done}, 32'd0);
            mem_wack = 1'b1;
            @(negedge clk); mem_wack = 1'b0;
            check("R6 done after ack", {31'd0, done}, 32'd1);
            check("R6 write dropped", {31'd0, mem_wr_req}, 32'd0);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule